// File: doc/BRIEF.md
# Activity-Driven Line Transceiver Power Controller

This block decides when the supply pump and the transmit drivers of a multi-channel serial line interface are switched on. It watches the logic-side data of the transmit channels and of the receive channels for transitions. When no channel has moved for a programmable idle window, it switches both enables off. Any later transition turns the supply pump back on. The transmit drivers follow only after a fixed settling delay, which gives the supplies time to recover.

Two override inputs sit above the activity logic. An active-low force-off shuts everything down unconditionally. An active-high force-on keeps the interface powered and holds the idle timer at zero. Once the block is down, for any reason, the idle timer stays expired. Releasing force-off alone does not wake the interface. Only a data transition or force-on does. All inputs are asynchronous and are synchronised inside the block. The receive paths are never gated by this block.

Top module: `linepwr_ctrl`

## Requirements
- R1: During reset and after it, both `pump_en` and `tx_drv_en` are low, and the idle timer starts expired. With no data transition and `force_on` low, the block stays down after reset.
- R2: With `force_off_n` high, a transition on any of the transmit or receive inputs raises `pump_en` in the third clock cycle after the input changes. Two cycles of this are the synchroniser and one is the timer register.
- R3: `tx_drv_en` rises exactly `WAKE_CYCLES` cycles after `pump_en` rises, provided `pump_en` stays high for that time.
- R4: With `force_on` low, `force_off_n` high and no transitions, `pump_en` and `tx_drv_en` fall `IDLE_CYCLES` cycles after `pump_en` was raised by the last transition.
- R5: A transition while the interface is powered restarts the idle window. Power then drops `IDLE_CYCLES` cycles after that transition takes effect.
- R6: Two cycles after `force_off_n` goes low, both enables are low. This holds whatever `force_on` is and whatever transitions occur.
- R7: When `force_off_n` returns high while `force_on` is low, the interface stays down, even if transitions happened while it was forced off. A later transition wakes it.
- R8: `force_on` high with `force_off_n` high raises `pump_en` three cycles later and keeps it high for longer than `IDLE_CYCLES`.
- R9: After `force_on` falls with no activity, power stays on for the full window. It drops `IDLE_CYCLES` + 2 cycles after the input change.
- R10: `tx_drv_en` is never high while `pump_en` is low. When `pump_en` falls, `tx_drv_en` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | N_TX | Transmit channel logic inputs (asynchronous) |
| rx_data | input | N_RX | Receive channel logic inputs (asynchronous) |
| force_off_n | input | 1 | Active-low forced shutdown, overrides everything |
| force_on | input | 1 | Active-high keep-alive, disables idle powerdown |
| pump_en | output | 1 | Supply charge-pump enable |
| tx_drv_en | output | 1 | Transmit driver enable; low means drivers at high impedance |

## Verification
Each of the six channels is toggled on its own from the powered-down state. This shows that every input reaches the wake logic with the same three-cycle latency and the same driver delay. Directed sequences cover several cases: a late transition that must push the timeout out, force-off with toggling data and force-on raised together, release of force-off onto an expired timer, and the force-on hold followed by a full window. These separate sticky powerdown from a plain level decode. A long random phase alternates busy and quiet stretches with occasional override flips. It is compared every cycle against a bench model of the timing rules, which exposes off-by-one errors in the window and the delay.

// File: rtl/lpw_pkg.sv
// Package: shared types of the line power controller.
// Assumes: nothing beyond IEEE 1800-2017.
package lpw_pkg;
    // States of the transmit-driver wake sequencer.
    typedef enum logic [1:0] {
        WK_DOWN = 2'd0,
        WK_RAMP = 2'd1,
        WK_UP   = 2'd2
    } wake_st_t;

    // Number of flops in front of any asynchronous input.
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/lp_sync2.sv
// Module: lp_sync2
// Two-flop synchroniser for W independent asynchronous bits.
// Assumes: each bit is a level, and a stale sample for one cycle is harmless.
module lp_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Capture, then re-time each bit; resets to all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/lp_sync_edge.sv
// Module: lp_sync_edge
// Synchronises W data lines and flags, per line, a change between
// consecutive synchronised samples (either polarity).
// Assumes: input pulses last longer than two clock periods.
module lp_sync_edge #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] chg
);
    logic [W-1:0] lvl;
    logic [W-1:0] prev_q;

    lp_sync2 #(.W(W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw),
        .q    (lvl)
    );

    // Hold the previous synchronised sample of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // Per-line change flag.
    for (genvar i = 0; i < W; i++) begin : g_chg
        assign chg[i] = lvl[i] ^ prev_q[i];
    end
endmodule

// File: rtl/lp_idle_timer.sv
// Module: lp_idle_timer
// Inactivity timer with a sticky expired flag. A forced-off interface
// sets the flag, a hold clears the count, and a kick restarts the window.
// Expiry happens when the count reaches IDLE_CYCLES - 1 without a kick.
// Assumes: IDLE_CYCLES >= 2 and CNT_W is wide enough for IDLE_CYCLES - 1.
module lp_idle_timer #(
    parameter int unsigned IDLE_CYCLES = 100,
    parameter int unsigned CNT_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             off_ok,
    input  logic             hold,
    input  logic             kick,
    output logic             expired,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYCLES - 1);

    // Priority: forced off, then hold or kick, then counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expired <= 1'b1;
            cnt     <= '0;
        end else if (!off_ok) begin
            expired <= 1'b1;
            cnt     <= '0;
        end else if (hold || kick) begin
            expired <= 1'b0;
            cnt     <= '0;
        end else if (!expired) begin
            if (cnt == LAST) begin
                expired <= 1'b1;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lp_wake_seq.sv
// Module: lp_wake_seq
// Delays transmit-driver enable by WAKE_CYCLES after the pump turns on,
// and drops it at once when the pump turns off.
// Assumes: WAKE_CYCLES >= 1.
module lp_wake_seq
    import lpw_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pump,
    output logic drv_ok
);
    localparam int unsigned   WC_W = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES + 1);
    localparam logic [WC_W-1:0] LAST = WC_W'(WAKE_CYCLES - 1);

    wake_st_t        st;
    logic [WC_W-1:0] cnt;

    // Step DOWN -> RAMP -> UP while the pump stays on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= WK_DOWN;
            cnt <= '0;
        end else if (!pump) begin
            st  <= WK_DOWN;
            cnt <= '0;
        end else begin
            case (st)
                WK_DOWN: begin
                    if (WAKE_CYCLES == 1) begin
                        st <= WK_UP;
                    end else begin
                        st  <= WK_RAMP;
                        cnt <= WC_W'(1);
                    end
                end
                WK_RAMP: begin
                    if (cnt == LAST) st  <= WK_UP;
                    else             cnt <= cnt + 1'b1;
                end
                WK_UP:   st <= WK_UP;
                default: st <= WK_DOWN;
            endcase
        end
    end

    assign drv_ok = (st == WK_UP);
endmodule

// File: rtl/linepwr_ctrl.sv
// Module: linepwr_ctrl (top)
// Activity-based power control for a serial line interface. It
// synchronises all inputs, restarts an idle window on any data change,
// applies force-off / force-on overrides and sequences the driver enable.
// Assumes: one clock; all inputs asynchronous to it.
module linepwr_ctrl #(
    parameter int unsigned N_TX        = 3,
    parameter int unsigned N_RX        = 3,
    parameter int unsigned IDLE_CYCLES = 32'd3000000000,
    parameter int unsigned WAKE_CYCLES = 10000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_TX-1:0] tx_data,
    input  logic [N_RX-1:0] rx_data,
    input  logic            force_off_n,
    input  logic            force_on,
    output logic            pump_en,
    output logic            tx_drv_en
);
    localparam int unsigned N_MON = N_TX + N_RX;
    localparam int unsigned CNT_W = $clog2(IDLE_CYCLES);

    logic [N_MON-1:0] chg;
    logic [1:0]       ctl_s;
    logic             off_n_s;
    logic             fon_s;
    logic             any_edge;
    logic             tmr_expired;
    logic [CNT_W-1:0] tmr_cnt;
    logic             drv_ok;

    lp_sync_edge #(.W(N_MON)) u_data (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({rx_data, tx_data}),
        .chg  (chg)
    );

    lp_sync2 #(.W(2)) u_ctl (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({force_on, force_off_n}),
        .q    (ctl_s)
    );

    assign off_n_s  = ctl_s[0];
    assign fon_s    = ctl_s[1];
    assign any_edge = |chg;

    lp_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES), .CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .off_ok (off_n_s),
        .hold   (fon_s),
        .kick   (any_edge),
        .expired(tmr_expired),
        .cnt    (tmr_cnt)
    );

    // Pump runs while not forced off and the idle window is open.
    assign pump_en = off_n_s & ~tmr_expired;

    lp_wake_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .pump  (pump_en),
        .drv_ok(drv_ok)
    );

    // Drivers only with the pump on and the delay done.
    assign tx_drv_en = pump_en & drv_ok;
endmodule

// File: rtl/lp_checker.sv
// Module: lp_checker
// Temporal properties of linepwr_ctrl, attached with bind.
// Assumes: rst_n low from time zero until after the first clock edges.
module lp_checker #(
    parameter int unsigned CNT_W       = 7,
    parameter int unsigned IDLE_CYCLES = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             force_off_n,
    input logic             pump_en,
    input logic             tx_drv_en,
    input logic             off_n_s,
    input logic             fon_s,
    input logic             any_edge,
    input logic             tmr_expired,
    input logic [CNT_W-1:0] tmr_cnt
);
    a_r10_tx_needs_pump: assert property (@(posedge clk) disable iff (!rst_n)
        tx_drv_en |-> pump_en);

    a_r6_force_off_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(force_off_n, 2) |-> !pump_en);

    a_r4_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pump_en) |-> (!off_n_s || $past(tmr_cnt) == CNT_W'(IDLE_CYCLES - 1)));

    a_r8_force_on_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fon_s && off_n_s) |=> (pump_en || !off_n_s));

    a_r7_release_stays_down: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(off_n_s) && tmr_expired && !fon_s && !any_edge) |=> !pump_en);

    a_r5_edge_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (any_edge && off_n_s) |=> !tmr_expired);
endmodule

bind linepwr_ctrl lp_checker #(.CNT_W(CNT_W), .IDLE_CYCLES(IDLE_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_off_n(force_off_n),
    .pump_en    (pump_en),
    .tx_drv_en  (tx_drv_en),
    .off_n_s    (off_n_s),
    .fon_s      (fon_s),
    .any_edge   (any_edge),
    .tmr_expired(tmr_expired),
    .tmr_cnt    (tmr_cnt)
);

// File: tb/test_linepwr_ctrl.sv
`timescale 1ns/1ps
module test_linepwr_ctrl;
    localparam int IDLE = 60;
    localparam int WAKE = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tx_d = '0;
    logic [2:0] rx_d = '0;
    logic       foff_d = 1'b1;
    logic       fon_d = 1'b0;
    logic       pump_en, tx_drv_en;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    linepwr_ctrl #(.N_TX(3), .N_RX(3), .IDLE_CYCLES(IDLE), .WAKE_CYCLES(WAKE)) i_linepwr_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_d), .rx_data(rx_d),
        .force_off_n(foff_d), .force_on(fon_d),
        .pump_en(pump_en), .tx_drv_en(tx_drv_en)
    );

    // Reference model built from the timing rules of R2..R10.
    logic [7:0] m1, m2, m3;
    logic       m_exp;
    int         m_cnt, m_run;

    function automatic logic exp_pump(logic off_n, logic expd);
        return off_n & ~expd;
    endfunction

    function automatic logic exp_tx(logic pump, int run);
        return pump && (run == WAKE);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 <= '0; m2 <= '0; m3 <= '0;
            m_exp <= 1'b1; m_cnt <= 0; m_run <= 0;
        end else begin
            m1 <= {fon_d, foff_d, rx_d, tx_d};
            m2 <= m1;
            m3 <= m2;
            if (!m2[6]) begin
                m_exp <= 1'b1; m_cnt <= 0;
            end else if (m2[7] || (m2[5:0] != m3[5:0])) begin
                m_exp <= 1'b0; m_cnt <= 0;
            end else if (!m_exp) begin
                if (m_cnt == IDLE - 1) begin m_exp <= 1'b1; m_cnt <= 0; end
                else m_cnt <= m_cnt + 1;
            end
            if (!exp_pump(m2[6], m_exp)) m_run <= 0;
            else if (m_run < WAKE) m_run <= m_run + 1;
        end
    end

    task automatic chk(string tag, logic act, logic expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, expv, $time);
        end
    endtask

    // Advance to the next falling edge and compare against the model.
    task automatic step();
        logic mp;
        @(negedge clk);
        if (rst_n) begin
            mp = exp_pump(m2[6], m_exp);
            chk("R4 model pump_en", pump_en, mp);
            chk("R10 model tx_drv_en", tx_drv_en, exp_tx(mp, m_run));
        end
    endtask

    task automatic toggle(int ch);
        if (ch < 3) tx_d[ch] = ~tx_d[ch];
        else        rx_d[ch-3] = ~rx_d[ch-3];
    endtask

    task automatic wait_down();
        repeat (IDLE + 20) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        bit busy;
        void'($urandom(32'd7));
        repeat (4) @(negedge clk);
        chk("R1 pump in reset", pump_en, 1'b0);
        chk("R1 tx in reset", tx_drv_en, 1'b0);
        rst_n = 1'b1;
        repeat (10) step();
        chk("R1 pump after reset", pump_en, 1'b0);
        chk("R1 tx after reset", tx_drv_en, 1'b0);

        // R2 / R3 / R4: each channel alone wakes the block.
        for (int ch = 0; ch < 6; ch++) begin
            wait_down();
            toggle(ch);
            step(); step();
            chk("R2 pump not yet", pump_en, 1'b0);
            step();
            chk("R2 pump on third cycle", pump_en, 1'b1);
            repeat (WAKE - 1) step();
            chk("R3 tx before delay", tx_drv_en, 1'b0);
            step();
            chk("R3 tx at delay", tx_drv_en, 1'b1);
            repeat (IDLE - WAKE - 1) step();
            chk("R4 pump before timeout", pump_en, 1'b1);
            step();
            chk("R4 pump at timeout", pump_en, 1'b0);
            chk("R4 tx at timeout", tx_drv_en, 1'b0);
        end

        // R5: a late transition pushes the timeout out.
        wait_down();
        toggle(0);
        repeat (3) step();
        repeat (30) step();
        toggle(4);
        repeat (IDLE + 2) step();
        chk("R5 still on after restart", pump_en, 1'b1);
        step();
        chk("R5 off after new window", pump_en, 1'b0);

        // R6: force-off wins over force-on and activity.
        wait_down();
        toggle(1);
        repeat (3 + WAKE + 2) step();
        chk("R6 tx up before force-off", tx_drv_en, 1'b1);
        foff_d = 1'b0; fon_d = 1'b1; toggle(2);
        step(); step();
        chk("R6 pump forced off", pump_en, 1'b0);
        chk("R6 tx forced off", tx_drv_en, 1'b0);
        for (int i = 0; i < 20; i++) begin
            toggle(i % 6);
            step();
            chk("R6 pump stays off", pump_en, 1'b0);
        end
        fon_d = 1'b0;
        repeat (3) step();

        // R7: release alone does not wake; a transition does.
        foff_d = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step();
            chk("R7 no wake on release", pump_en, 1'b0);
        end
        toggle(5);
        repeat (3) step();
        chk("R7 wake by transition", pump_en, 1'b1);

        // R8: force-on keeps the interface up.
        wait_down();
        fon_d = 1'b1;
        repeat (3) step();
        chk("R8 pump by force-on", pump_en, 1'b1);
        repeat (3 * IDLE) step();
        chk("R8 pump held", pump_en, 1'b1);
        chk("R8 tx held", tx_drv_en, 1'b1);

        // R9: full window after force-on falls.
        fon_d = 1'b0;
        repeat (IDLE + 1) step();
        chk("R9 on through window", pump_en, 1'b1);
        step();
        chk("R9 off after window", pump_en, 1'b0);

        // Random phase: busy/quiet stretches, rare override flips.
        busy = 1'b1;
        for (int i = 0; i < 20000; i++) begin
            int r;
            if (i % 500 == 0) busy = ($urandom % 2) == 1;
            r = int'($urandom % 1000);
            if (busy && r < 30) toggle(int'($urandom % 6));
            if (r == 999) foff_d = ~foff_d;
            if (r == 998) fon_d = ~fon_d;
            step();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule